// File: doc/BRIEF.md
# Root clock configuration commit register bank

This block is the register front end of a root clock generator. Software reaches it over a simple word-wide read/write port. It holds one command register and four configuration registers: the divider/source/mode register, and the M, N and D counter values. Writes to the four configuration registers only reach a set of shadow copies. A pending flag for each register records that its shadow differs from what the generator is using.

A commit is started by setting the update request bit in the command register. After a fixed synchronisation delay, every shadow is copied into the active set on one clock edge, and a one-cycle load strobe marks that edge. On the same edge the hardware clears the update bit and the pending flags. Software polls the update bit to learn that the new setting is in force. The active values drive the generator directly. The command register also carries the root-enable control and a status bit that reads 1 while the root is stopped.

Top module: `rcg_cfg_bank`

## Requirements
- R1: The byte offsets are: command at 0x00, divider/source/mode at 0x04, M at 0x08, N at 0x0C and D at 0x10. A write to any other offset, including an offset that is not a multiple of four, changes nothing, and a read of such an offset returns 0.
- R2: Command bit 1 is the root-enable control and can be read back. `root_run_o` follows it one cycle after the write. Command bit 31 reads 1 while the root is disabled and 0 while it is enabled.
- R3: A write to a configuration register changes only its shadow, and a read returns the shadow value. The generator outputs hold their values on every cycle without a commit.
- R4: Command bits 7:4 are pending flags: bit 4 for divider/source/mode, bit 5 for M, bit 6 for N and bit 7 for D. A flag is set by a write to its register and cleared by the commit.
- R5: Writing command bit 0 as 1 while no update is pending sets the bit. Exactly SYNC_CYCLES clock edges later, the active set loads from the shadows. On that same edge bit 0 clears, and `gen_load_o` goes high for exactly that one cycle.
- R6: Shadow writes accepted while an update is pending are taken by that commit. A further bit 0 request while an update is pending does not restart the delay. Writing bit 0 as 0 does not cancel a pending update.
- R7: A shadow write on the commit edge itself is not in the new active set, and its pending flag stays set after the commit.
- R8: The divider/source/mode register holds the divider in bits 4:0, the source select in bits 10:8 and the counter mode in bits 13:12, where 2 means dual-edge M/N:D. All other bits read 0.
- R9: The active counter mode is the committed mode field only when the committed N is nonzero. Otherwise it is 0, and only the divider applies.
- R10: M, N and D each store MND_W bits. A read of N or D sign-extends bit MND_W-1 to 32 bits, and a read of M zero-extends.
- R11: After reset, all shadows, active values, flags and the update bit are 0, the root is disabled, and the command register reads 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator-side clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; data appears the next cycle |
| bus_addr_i | input | ADDR_W | Byte offset from the block base |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| gen_div_o | output | 5 | Active pre-divider |
| gen_src_o | output | 3 | Active source select |
| gen_mode_o | output | 2 | Active counter mode |
| gen_m_o | output | MND_W | Active M |
| gen_n_o | output | MND_W | Active N |
| gen_d_o | output | MND_W | Active D |
| gen_load_o | output | 1 | One-cycle strobe on the commit edge |
| root_run_o | output | 1 | Root enable as seen by the generator |

## Verification
The bench builds the block with MND_W = 8 and SYNC_CYCLES = 3. With these values the sign bit of N and D is set by a value as small as 0x80, so the sign extension of R10 is exercised with short vectors. The short delay also lets a directed sequence place writes on every cycle of a pending commit, including the commit edge itself. That covers the in-flight and same-edge cases of R6 and R7, and it shows that a repeated request does not extend the delay.

// File: rtl/rcg_cfg_pkg.sv
package rcg_cfg_pkg;
  localparam int unsigned OFF_CMD = 'h00;
  localparam int unsigned OFF_CFG = 'h04;
  localparam int unsigned OFF_M   = 'h08;
  localparam int unsigned OFF_N   = 'h0C;
  localparam int unsigned OFF_D   = 'h10;

  // pending flag indices, placed at command bits 7:4
  localparam int unsigned PND_CFG = 0;
  localparam int unsigned PND_M   = 1;
  localparam int unsigned PND_N   = 2;
  localparam int unsigned PND_D   = 3;
  localparam int unsigned NUM_PND = 4;

  localparam int unsigned DIV_W  = 5;
  localparam int unsigned SRC_W  = 3;
  localparam int unsigned MODE_W = 2;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [SRC_W-1:0]  src;
    logic [DIV_W-1:0]  div;
  } cfg_fields_t;

  function automatic cfg_fields_t unpack_cfg(input logic [31:0] w);
    cfg_fields_t f;
    f.div  = w[4:0];
    f.src  = w[10:8];
    f.mode = w[13:12];
    return f;
  endfunction

  function automatic logic [31:0] pack_cfg(input cfg_fields_t f);
    logic [31:0] w;
    w        = '0;
    w[4:0]   = f.div;
    w[10:8]  = f.src;
    w[13:12] = f.mode;
    return w;
  endfunction
endpackage

// File: rtl/rcg_cfg_shadow.sv
module rcg_cfg_shadow
  import rcg_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned MND_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               commit_i,
  output cfg_fields_t        cfg_q,
  output logic [MND_W-1:0]   m_q,
  output logic [MND_W-1:0]   n_q,
  output logic [MND_W-1:0]   d_q,
  output logic [NUM_PND-1:0] pend_q
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_M   = ADDR_W'(OFF_M);
  localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(OFF_N);
  localparam logic [ADDR_W-1:0] A_D   = ADDR_W'(OFF_D);

  logic [NUM_PND-1:0] hit;

  always_comb begin
    hit          = '0;
    hit[PND_CFG] = wr_i && (addr_i == A_CFG);
    hit[PND_M]   = wr_i && (addr_i == A_M);
    hit[PND_N]   = wr_i && (addr_i == A_N);
    hit[PND_D]   = wr_i && (addr_i == A_D);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      m_q   <= '0;
      n_q   <= '0;
      d_q   <= '0;
    end else begin
      if (hit[PND_CFG]) cfg_q <= unpack_cfg(wdata_i);
      if (hit[PND_M])   m_q   <= wdata_i[MND_W-1:0];
      if (hit[PND_N])   n_q   <= wdata_i[MND_W-1:0];
      if (hit[PND_D])   d_q   <= wdata_i[MND_W-1:0];
    end
  end

  // one pending flag per register; a write on the commit edge wins
  for (genvar g = 0; g < NUM_PND; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= (pend_q[g] && !commit_i) || hit[g];
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    hit[PND_N] |=> pend_q[PND_N]); // R4
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !wr_i) |=> (pend_q == '0)); // R4
  AST_SAME_EDGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (commit_i && hit[PND_D]) |=> pend_q[PND_D]); // R7
endmodule

// File: rtl/rcg_cfg_commit.sv
module rcg_cfg_commit #(
  parameter int unsigned SYNC_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int unsigned CNT_W = (SYNC_CYCLES > 1) ? $clog2(SYNC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign commit_o = busy_o && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (req_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (commit_o) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt_q <= LAST)); // R5
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !busy_o); // R5
  AST_REQ_ARMS: assert property (@(posedge clk) disable iff (rst)
    (req_i && !busy_o) |=> busy_o); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !commit_o) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/rcg_cfg_active.sv
module rcg_cfg_active
  import rcg_cfg_pkg::*;
#(
  parameter int unsigned MND_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  cfg_fields_t       cfg_i,
  input  logic [MND_W-1:0]  m_i,
  input  logic [MND_W-1:0]  n_i,
  input  logic [MND_W-1:0]  d_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [MND_W-1:0]  m_o,
  output logic [MND_W-1:0]  n_o,
  output logic [MND_W-1:0]  d_o,
  output logic              load_o
);
  logic [MODE_W-1:0] mode_eff;

  // the M/N:D counter only runs with a nonzero N
  assign mode_eff = (n_i != '0) ? cfg_i.mode : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o  <= '0;
      src_o  <= '0;
      mode_o <= '0;
      m_o    <= '0;
      n_o    <= '0;
      d_o    <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= commit_i;
      if (commit_i) begin
        div_o  <= cfg_i.div;
        src_o  <= cfg_i.src;
        mode_o <= mode_eff;
        m_o    <= m_i;
        n_o    <= n_i;
        d_o    <= d_i;
      end
    end
  end

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(div_o) && $stable(src_o) && $stable(mode_o)
                   && $stable(m_o) && $stable(n_o) && $stable(d_o))); // R3
  AST_MODE_NEEDS_N: assert property (@(posedge clk) disable iff (rst)
    (mode_o != '0) |-> (n_o != '0)); // R9
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o); // R5
endmodule

// File: rtl/rcg_cfg_bank.sv
module rcg_cfg_bank
  import rcg_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned MND_W       = 16,
  parameter int unsigned SYNC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [4:0]        gen_div_o,
  output logic [2:0]        gen_src_o,
  output logic [1:0]        gen_mode_o,
  output logic [MND_W-1:0]  gen_m_o,
  output logic [MND_W-1:0]  gen_n_o,
  output logic [MND_W-1:0]  gen_d_o,
  output logic              gen_load_o,
  output logic              root_run_o
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_M   = ADDR_W'(OFF_M);
  localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(OFF_N);
  localparam logic [ADDR_W-1:0] A_D   = ADDR_W'(OFF_D);
  localparam int unsigned EXT_W = 32 - MND_W;

  cfg_fields_t        sh_cfg;
  logic [MND_W-1:0]   sh_m, sh_n, sh_d;
  logic [NUM_PND-1:0] pend;
  logic               busy, commit, cmd_wr, root_q;
  logic [31:0]        cmd_word, rd_mux;

  assign cmd_wr = bus_wr_i && (bus_addr_i == A_CMD);

  rcg_cfg_shadow #(.ADDR_W(ADDR_W), .MND_W(MND_W)) i_shadow (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .commit_i (commit),
    .cfg_q    (sh_cfg),
    .m_q      (sh_m),
    .n_q      (sh_n),
    .d_q      (sh_d),
    .pend_q   (pend)
  );

  rcg_cfg_commit #(.SYNC_CYCLES(SYNC_CYCLES)) i_commit (
    .clk      (clk),
    .rst      (rst),
    .req_i    (cmd_wr && bus_wdata_i[0]),
    .busy_o   (busy),
    .commit_o (commit)
  );

  rcg_cfg_active #(.MND_W(MND_W)) i_active (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit),
    .cfg_i    (sh_cfg),
    .m_i      (sh_m),
    .n_i      (sh_n),
    .d_i      (sh_d),
    .div_o    (gen_div_o),
    .src_o    (gen_src_o),
    .mode_o   (gen_mode_o),
    .m_o      (gen_m_o),
    .n_o      (gen_n_o),
    .d_o      (gen_d_o),
    .load_o   (gen_load_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         root_q <= 1'b0;
    else if (cmd_wr) root_q <= bus_wdata_i[1];
  end
  assign root_run_o = root_q;

  always_comb begin
    cmd_word      = '0;
    cmd_word[31]  = !root_q;
    cmd_word[7:4] = pend;
    cmd_word[1]   = root_q;
    cmd_word[0]   = busy;
  end

  always_comb begin
    unique case (bus_addr_i)
      A_CMD:   rd_mux = cmd_word;
      A_CFG:   rd_mux = pack_cfg(sh_cfg);
      A_M:     rd_mux = {{EXT_W{1'b0}}, sh_m};
      A_N:     rd_mux = {{EXT_W{sh_n[MND_W-1]}}, sh_n};
      A_D:     rd_mux = {{EXT_W{sh_d[MND_W-1]}}, sh_d};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end

  AST_ROOT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (root_run_o == $past(bus_wdata_i[1]))); // R2
  AST_LOAD_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
    gen_load_o |-> $past(busy)); // R5
endmodule

// File: tb/test_rcg_cfg_bank.sv
module test_rcg_cfg_bank;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned MND_W  = 8;
  localparam int unsigned SYNC   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [4:0]        g_div;
  logic [2:0]        g_src;
  logic [1:0]        g_mode;
  logic [MND_W-1:0]  g_m, g_n, g_d;
  logic              g_load, g_run;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rcg_cfg_bank #(.ADDR_W(ADDR_W), .MND_W(MND_W), .SYNC_CYCLES(SYNC)) i_rcg_cfg_bank (
    .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .gen_div_o(g_div), .gen_src_o(g_src),
    .gen_mode_o(g_mode), .gen_m_o(g_m), .gen_n_o(g_n), .gen_d_o(g_d),
    .gen_load_o(g_load), .root_run_o(g_run)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  req;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd11, 5'h00, 32'h0,        32'h8000_0000}, // R11
    '{1'b0, 8'd8,  5'h04, 32'hFFFF_FFFF, 32'h0},
    '{1'b1, 8'd8,  5'h04, 32'h0,        32'h0000_371F}, // R8
    '{1'b1, 8'd4,  5'h00, 32'h0,        32'h8000_0010}, // R4
    '{1'b0, 8'd10, 5'h08, 32'h0000_01A5, 32'h0},
    '{1'b1, 8'd10, 5'h08, 32'h0,        32'h0000_00A5}, // R10
    '{1'b0, 8'd10, 5'h0C, 32'h0000_0080, 32'h0},
    '{1'b1, 8'd10, 5'h0C, 32'h0,        32'hFFFF_FF80}, // R10
    '{1'b0, 8'd10, 5'h10, 32'h0000_007F, 32'h0},
    '{1'b1, 8'd10, 5'h10, 32'h0,        32'h0000_007F}, // R10
    '{1'b1, 8'd4,  5'h00, 32'h0,        32'h8000_00F0}, // R4
    '{1'b0, 8'd1,  5'h14, 32'h1234_5678, 32'h0},
    '{1'b1, 8'd1,  5'h14, 32'h0,        32'h0},          // R1
    '{1'b1, 8'd1,  5'h02, 32'h0,        32'h0},          // R1
    '{1'b0, 8'd2,  5'h00, 32'h0000_0002, 32'h0},
    '{1'b1, 8'd2,  5'h00, 32'h0,        32'h0000_00F2}  // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    tick();
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    tick(); tick();
    rst = 1'b0;
    tick();
    chk("R11 div", 32'(g_div), 0);
    chk("R11 run", 32'(g_run), 0);
    chk("R11 load", 32'(g_load), 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) begin
        bus_read(VECS[i].a, r);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), r, VECS[i].e);
      end else begin
        bus_write(VECS[i].a, VECS[i].d);
      end
    end

    // R3: nothing committed yet; R2: root enabled
    chk("R3 div held", 32'(g_div), 0);
    chk("R3 m held", 32'(g_m), 0);
    chk("R2 run", 32'(g_run), 1);

    // R5: commit timing
    bus_write(5'h00, 32'h3);
    tick(); tick();
    chk("R5 before commit div", 32'(g_div), 0);
    chk("R5 before commit load", 32'(g_load), 0);
    tick();
    chk("R5 load", 32'(g_load), 1);
    chk("R5 div", 32'(g_div), 32'h1F);
    chk("R8 src", 32'(g_src), 7);
    chk("R9 mode kept", 32'(g_mode), 3);
    chk("R3 m", 32'(g_m), 32'hA5);
    chk("R3 n", 32'(g_n), 32'h80);
    chk("R3 d", 32'(g_d), 32'h7F);
    tick();
    chk("R5 load drop", 32'(g_load), 0);
    bus_read(5'h00, r);
    chk("R4 flags cleared", r, 32'h2);

    // R6: in-flight write and repeated request
    bus_write(5'h00, 32'h3);
    bus_write(5'h08, 32'h33);
    bus_write(5'h00, 32'h3);
    tick();
    chk("R6 load no restart", 32'(g_load), 1);
    chk("R6 m taken", 32'(g_m), 32'h33);
    bus_read(5'h00, r);
    chk("R6 cmd", r, 32'h2);

    // R6: writing bit 0 as 0 does not cancel
    bus_write(5'h00, 32'h3);
    bus_write(5'h00, 32'h2);
    bus_write(5'h10, 32'h44);
    tick();
    chk("R6 no cancel load", 32'(g_load), 1);
    chk("R6 d taken", 32'(g_d), 32'h44);

    // R7: write on the commit edge
    bus_write(5'h00, 32'h3);
    tick(); tick();
    bus_write(5'h10, 32'h11);
    chk("R7 load", 32'(g_load), 1);
    chk("R7 d old", 32'(g_d), 32'h44);
    bus_read(5'h00, r);
    chk("R7 flag kept", r, 32'h82);
    bus_read(5'h10, r);
    chk("R7 shadow", r, 32'h11);
    bus_write(5'h00, 32'h3);
    tick(); tick(); tick();
    chk("R7 later commit", 32'(g_d), 32'h11);

    // R9: mode forced off with N = 0
    bus_write(5'h0C, 32'h0);
    bus_write(5'h04, 32'h2000);
    bus_write(5'h00, 32'h3);
    tick(); tick(); tick();
    chk("R9 mode zero", 32'(g_mode), 0);
    chk("R9 n zero", 32'(g_n), 0);
    bus_write(5'h0C, 32'h5);
    bus_write(5'h00, 32'h3);
    tick(); tick(); tick();
    chk("R9 mode dual", 32'(g_mode), 2);
    chk("R9 n", 32'(g_n), 5);

    // R2: root off
    bus_write(5'h00, 32'h0);
    chk("R2 run off", 32'(g_run), 0);
    bus_read(5'h00, r);
    chk("R2 off flag", r, 32'h8000_0000);

    // R11: reset again
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk("R11 mode", 32'(g_mode), 0);
    chk("R11 n", 32'(g_n), 0);
    bus_read(5'h00, r);
    chk("R11 cmd", r, 32'h8000_0000);
    bus_read(5'h04, r);
    chk("R11 cfg", r, 0);

    finish_run();
  end
endmodule